// File: doc/BRIEF.md
# ADC conversion mode sequencer

This block is the digital controller in front of a four-input successive-approximation converter. Software sets an operating mode and its selections on a configuration bus, then pulses a start command. The block picks the converter input, strobes the converter, waits for its done pulse, and writes the 8-bit result into one of four result registers. It raises a sticky completion flag, and an interrupt line when the flag is enabled.

There are five modes. The first two convert one fixed channel, either once or repeatedly. The next two scan the enabled channels, either once or repeatedly. The last converts a pair of channels alternately and without end. The modes differ in which result register receives each conversion and in which conversion sets the flag.

The controller has three states:
- `S_IDLE` waits for an accepted start.
- `S_LAUNCH` drives the one-cycle converter strobe.
- `S_WAIT` waits for the converter's done pulse.

The transitions are:
- `S_IDLE` moves to `S_LAUNCH` on an accepted start.
- `S_LAUNCH` always moves to `S_WAIT`.
- `S_WAIT` moves to `S_LAUNCH` on done when the run continues.
- `S_WAIT` moves to `S_IDLE` on done when the run ends. A run ends when a single-pass mode completes or a stop is pending.

Configuration is captured when a start is accepted.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the block is idle: busy, done_flag, irq and conv_start are low and all four result registers read zero.
- R2: Each conversion begins with conv_start high for exactly one cycle, with conv_ch valid. conv_ch holds steady until the done pulse, and the next strobe comes only after that done pulse.
- R3: Mode 0 (fixed single) converts cfg_fixed_ch once. The result goes to result register number cfg_fixed_ch, the flag sets, and the block returns to idle.
- R4: Mode 1 (fixed continuous) converts cfg_fixed_ch repeatedly. Results are written to registers 0, 1, 2, 3 and then wrap back to 0.
- R5: In mode 1, when cfg_grp_irq is 1 the flag sets on every fourth result (the one written to register 3). When cfg_grp_irq is 0 the flag never sets.
- R6: Mode 2 (scan single) converts each channel enabled in cfg_scan_mask once, from the lowest number to the highest. Each result goes to the register numbered by its channel. The flag sets after the highest enabled channel, and the block returns to idle.
- R7: Mode 2 with one mask bit set behaves exactly like mode 0 on that channel.
- R8: Mode 3 (scan continuous) behaves like mode 2, but after the last enabled channel it sets the flag and restarts from the lowest enabled channel.
- R9: Mode 4 (dual continuous) alternates cfg_dual_a and cfg_dual_b, starting with cfg_dual_a. Results are written to registers 0, 1, 2, 3 and then wrap, and the flag sets on each result written to register 3.
- R10: A start is ignored, and busy stays low, in any of these cases: the mode code is 5 to 7; the mode is 2 or 3 with an all-zero mask; or the block is already busy.
- R11: A stop while busy lets the conversion in flight finish and store its result, and then the block goes idle. A stop while idle has no effect.
- R12: done_flag stays set until flag_clr. A set in the same cycle as a clear wins. irq equals done_flag AND cfg_irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Mode code 0..4; 5..7 reserved |
| cfg_fixed_ch | input | 2 | Channel used in modes 0 and 1 |
| cfg_scan_mask | input | 4 | Channel enable mask for modes 2 and 3 |
| cfg_dual_a | input | 2 | First channel of the mode 4 pair |
| cfg_dual_b | input | 2 | Second channel of the mode 4 pair |
| cfg_grp_irq | input | 1 | Flag every fourth result in mode 1 |
| cfg_irq_en | input | 1 | Interrupt enable |
| cmd_start | input | 1 | Start command, one-cycle pulse |
| cmd_stop | input | 1 | Stop command, one-cycle pulse |
| flag_clr | input | 1 | Clears done_flag |
| conv_ch | output | 2 | Converter input select |
| conv_start | output | 1 | Converter start strobe |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 8 | Converter result, valid with conv_done |
| res_bus | output | 32 | Result register k on bits 8k+7..8k |
| busy | output | 1 | High outside S_IDLE |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |

## Verification
Several corner cases are targeted:
- A ring slot that is wrongly tied to the channel number would make the continuous fixed and dual modes write the same register repeatedly, and the per-cycle register comparison catches this.
- A scan that starts from the wrong end, or a restart that skips back to channel 0 instead of the lowest enabled channel, shows up as a wrong conv_ch at a strobe.
- A stop that aborts the conversion in flight loses the final result. A stop that is ignored leaves busy high.
- A flag clear that beats a simultaneous set, or a start accepted with an all-zero mask or a reserved mode, makes busy or done_flag diverge from the model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [2:0] {
        M_FIX_ONE  = 3'd0,
        M_FIX_RUN  = 3'd1,
        M_SCAN_ONE = 3'd2,
        M_SCAN_RUN = 3'd3,
        M_DUAL_RUN = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LAUNCH = 2'd1,
        S_WAIT   = 2'd2
    } state_e;
endpackage

// File: rtl/adc_seq_chsel.sv
module adc_seq_chsel #(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input  logic [NCH-1:0] mask,
    input  logic [CHW-1:0] cur,
    output logic [CHW-1:0] first_ch,
    output logic [CHW-1:0] next_ch,
    output logic           has_next,
    output logic           any_en
);
    // Scan downwards so the lowest qualifying channel is the last one written.
    always_comb begin
        first_ch = '0;
        next_ch  = '0;
        has_next = 1'b0;
        any_en   = |mask;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i]) begin
                first_ch = CHW'(i);
            end
            if (mask[i] && (i > int'(cur))) begin
                next_ch  = CHW'(i);
                has_next = 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_seq_resbank.sv
module adc_seq_resbank #(
    parameter int NSLOT = 4,
    parameter int DW    = 8,
    parameter int SW    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SW-1:0]       wr_slot,
    input  logic [DW-1:0]       wr_data,
    output logic [NSLOT*DW-1:0] res_flat
);
    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        logic [DW-1:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en && (wr_slot == SW'(k))) begin
                slot_q <= wr_data;
            end
        end

        assign res_flat[k*DW +: DW] = slot_q;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     cfg_mode,
    input  logic [CHW-1:0] cfg_fixed_ch,
    input  logic [NCH-1:0] cfg_scan_mask,
    input  logic [CHW-1:0] cfg_dual_a,
    input  logic [CHW-1:0] cfg_dual_b,
    input  logic           cfg_grp_irq,
    input  logic           cmd_start,
    input  logic           cmd_stop,
    input  logic           flag_clr,
    input  logic           conv_done,
    output logic [CHW-1:0] conv_ch,
    output logic           conv_start,
    output logic           busy,
    output logic           done_flag,
    output logic           wr_en,
    output logic [CHW-1:0] wr_slot
);
    localparam logic [CHW-1:0] RING_LAST = CHW'(NCH - 1);

    state_e         state_q, state_d;
    mode_e          mode_q;
    logic [NCH-1:0] mask_q;
    logic [CHW-1:0] dual_a_q, dual_b_q, ch_q, ring_q, ring_nx, ch_nx, slot;
    logic           grp_q, stop_q, flag_q;
    logic           flag_hit, halt_mode, halt_all, done_ev, start_ok;
    logic           is_scan_cfg, ring_last;
    logic [NCH-1:0] sel_mask;
    logic [CHW-1:0] first_ch, next_ch;
    logic           has_next, any_en;

    // In idle the selector looks at the live mask (for the first channel);
    // once running it looks at the captured one.
    assign sel_mask = (state_q == S_IDLE) ? cfg_scan_mask : mask_q;

    adc_seq_chsel #(.NCH(NCH), .CHW(CHW)) u_chsel (
        .mask     (sel_mask),
        .cur      (ch_q),
        .first_ch (first_ch),
        .next_ch  (next_ch),
        .has_next (has_next),
        .any_en   (any_en)
    );

    assign is_scan_cfg = (cfg_mode == M_SCAN_ONE) || (cfg_mode == M_SCAN_RUN);
    assign start_ok    = cmd_start && (cfg_mode <= 3'd4) && (!is_scan_cfg || any_en);
    assign done_ev     = (state_q == S_WAIT) && conv_done;
    assign ring_last   = (ring_q == RING_LAST);
    assign ring_nx     = ring_last ? '0 : ring_q + 1'b1;

    // Per-mode placement, flag rule and next channel.
    always_comb begin
        slot      = ch_q;
        flag_hit  = 1'b0;
        halt_mode = 1'b0;
        ch_nx     = ch_q;
        unique case (mode_q)
            M_FIX_ONE: begin
                flag_hit  = 1'b1;
                halt_mode = 1'b1;
            end
            M_FIX_RUN: begin
                slot     = ring_q;
                flag_hit = ring_last && grp_q;
            end
            M_SCAN_ONE: begin
                flag_hit  = !has_next;
                halt_mode = !has_next;
                ch_nx     = next_ch;
            end
            M_SCAN_RUN: begin
                flag_hit = !has_next;
                ch_nx    = has_next ? next_ch : first_ch;
            end
            M_DUAL_RUN: begin
                slot     = ring_q;
                flag_hit = ring_last;
                ch_nx    = ring_q[0] ? dual_a_q : dual_b_q;
            end
            default: begin
                halt_mode = 1'b1;
            end
        endcase
    end

    assign halt_all = halt_mode || stop_q || cmd_stop;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_ok) state_d = S_LAUNCH;
            S_LAUNCH: state_d = S_WAIT;
            S_WAIT:   if (conv_done) state_d = halt_all ? S_IDLE : S_LAUNCH;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Captured configuration, channel, ring position and pending stop.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= M_FIX_ONE;
            mask_q   <= '0;
            dual_a_q <= '0;
            dual_b_q <= '0;
            grp_q    <= 1'b0;
            ch_q     <= '0;
            ring_q   <= '0;
            stop_q   <= 1'b0;
        end else if ((state_q == S_IDLE) && start_ok) begin
            mode_q   <= mode_e'(cfg_mode);
            mask_q   <= cfg_scan_mask;
            dual_a_q <= cfg_dual_a;
            dual_b_q <= cfg_dual_b;
            grp_q    <= cfg_grp_irq;
            ring_q   <= '0;
            stop_q   <= 1'b0;
            if (is_scan_cfg) begin
                ch_q <= first_ch;
            end else if (cfg_mode == M_DUAL_RUN) begin
                ch_q <= cfg_dual_a;
            end else begin
                ch_q <= cfg_fixed_ch;
            end
        end else if (state_q != S_IDLE) begin
            if (cmd_stop) begin
                stop_q <= 1'b1;
            end
            if (done_ev) begin
                ch_q   <= ch_nx;
                ring_q <= ring_nx;
                if (halt_all) begin
                    stop_q <= 1'b0;
                end
            end
        end
    end

    // Sticky completion flag: a set wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (done_ev && flag_hit) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    // Outputs.
    always_comb begin
        conv_start = (state_q == S_LAUNCH);
        busy       = (state_q != S_IDLE);
        conv_ch    = ch_q;
        done_flag  = flag_q;
        wr_en      = done_ev;
        wr_slot    = slot;
    end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int CHW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_mode,
    input  logic [CHW-1:0]    cfg_fixed_ch,
    input  logic [NCH-1:0]    cfg_scan_mask,
    input  logic [CHW-1:0]    cfg_dual_a,
    input  logic [CHW-1:0]    cfg_dual_b,
    input  logic              cfg_grp_irq,
    input  logic              cfg_irq_en,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              flag_clr,
    output logic [CHW-1:0]    conv_ch,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [DW-1:0]     conv_data,
    output logic [NCH*DW-1:0] res_bus,
    output logic              busy,
    output logic              done_flag,
    output logic              irq
);
    logic           wr_en;
    logic [CHW-1:0] wr_slot;

    adc_seq_ctrl #(.NCH(NCH), .CHW(CHW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_mode      (cfg_mode),
        .cfg_fixed_ch  (cfg_fixed_ch),
        .cfg_scan_mask (cfg_scan_mask),
        .cfg_dual_a    (cfg_dual_a),
        .cfg_dual_b    (cfg_dual_b),
        .cfg_grp_irq   (cfg_grp_irq),
        .cmd_start     (cmd_start),
        .cmd_stop      (cmd_stop),
        .flag_clr      (flag_clr),
        .conv_done     (conv_done),
        .conv_ch       (conv_ch),
        .conv_start    (conv_start),
        .busy          (busy),
        .done_flag     (done_flag),
        .wr_en         (wr_en),
        .wr_slot       (wr_slot)
    );

    adc_seq_resbank #(.NSLOT(NCH), .DW(DW), .SW(CHW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_data  (conv_data),
        .res_flat (res_bus)
    );

    assign irq = done_flag & cfg_irq_en;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int CHW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cmd_start,
    input logic           flag_clr,
    input logic           conv_done,
    input logic           conv_start,
    input logic [CHW-1:0] conv_ch,
    input logic           busy,
    input logic           done_flag
);
    // R2
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R2
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);

    // R2
    ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_done) |=> $stable(conv_ch));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_start) |=> !busy);

    // R12
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !flag_clr) |=> done_flag);

    // R12
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(conv_done));
endmodule

bind adc_seq_top adc_seq_chk #(.CHW(CHW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .flag_clr   (flag_clr),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .conv_ch    (conv_ch),
    .busy       (busy),
    .done_flag  (done_flag)
);

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_mode = '0;
    logic [1:0]  cfg_fixed_ch = '0;
    logic [3:0]  cfg_scan_mask = '0;
    logic [1:0]  cfg_dual_a = '0;
    logic [1:0]  cfg_dual_b = '0;
    logic        cfg_grp_irq = 1'b0;
    logic        cfg_irq_en = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_stop = 1'b0;
    logic        flag_clr = 1'b0;
    logic [1:0]  conv_ch;
    logic        conv_start;
    logic        conv_done = 1'b0;
    logic [7:0]  conv_data = '0;
    logic [31:0] res_bus;
    logic        busy, done_flag, irq;

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // Reference model state.
    bit       m_active, m_stop, m_flag, m_grp, m_end, m_fset;
    int       m_mode, m_pos, m_cnt, m_ch, m_slot;
    int       m_seq[$];
    logic [7:0] m_res[4];

    // Converter model state.
    int cd_cnt = 0;
    int cnv_n = 0;
    logic [1:0] pend_ch = '0;

    always #4 clk = ~clk;

    adc_seq_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_fixed_ch(cfg_fixed_ch),
        .cfg_scan_mask(cfg_scan_mask), .cfg_dual_a(cfg_dual_a), .cfg_dual_b(cfg_dual_b),
        .cfg_grp_irq(cfg_grp_irq), .cfg_irq_en(cfg_irq_en), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .flag_clr(flag_clr), .conv_ch(conv_ch),
        .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data),
        .res_bus(res_bus), .busy(busy), .done_flag(done_flag), .irq(irq)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    function automatic bit start_valid();
        if (cfg_mode > 3'd4) return 1'b0;
        if ((cfg_mode == 3'd2 || cfg_mode == 3'd3) && cfg_scan_mask == 4'd0) return 1'b0;
        return 1'b1;
    endfunction

    // Behavioural model, advanced on every rising edge from bench-driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_stop = 0; m_flag = 0; m_grp = 0;
            m_mode = 0; m_pos = 0; m_cnt = 0;
            m_seq.delete();
            for (int k = 0; k < 4; k++) m_res[k] = '0;
        end else begin
            m_fset = 0;
            if (m_active && conv_done) begin
                m_ch   = m_seq[m_pos];
                m_slot = (m_mode == 1 || m_mode == 4) ? (m_cnt % 4) : m_ch;
                m_res[m_slot] = conv_data;
                m_end = 0;
                case (m_mode)
                    0: begin m_fset = 1; m_end = 1; end
                    1: m_fset = ((m_cnt % 4) == 3) && m_grp;
                    2: begin m_fset = (m_pos == m_seq.size() - 1); m_end = m_fset; end
                    3: m_fset = (m_pos == m_seq.size() - 1);
                    default: m_fset = ((m_cnt % 4) == 3);
                endcase
                m_cnt++;
                m_pos = (m_pos + 1) % m_seq.size();
                if (m_end || m_stop || cmd_stop) begin
                    m_active = 0;
                    m_stop   = 0;
                end
            end else if (m_active && cmd_stop) begin
                m_stop = 1;
            end else if (!m_active && cmd_start && start_valid()) begin
                m_seq.delete();
                m_mode = int'(cfg_mode);
                m_grp  = cfg_grp_irq;
                if (m_mode == 2 || m_mode == 3) begin
                    for (int k = 0; k < 4; k++) if (cfg_scan_mask[k]) m_seq.push_back(k);
                end else if (m_mode == 4) begin
                    m_seq.push_back(int'(cfg_dual_a));
                    m_seq.push_back(int'(cfg_dual_b));
                end else begin
                    m_seq.push_back(int'(cfg_fixed_ch));
                end
                m_pos = 0; m_cnt = 0; m_stop = 0; m_active = 1;
            end
            if (m_fset) m_flag = 1;
            else if (flag_clr) m_flag = 0;
        end
    end

    // Per-cycle comparison and converter model on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == m_active, "busy", 32'(busy), 32'(m_active));
            chk(done_flag == m_flag, "done_flag", 32'(done_flag), 32'(m_flag));
            chk(irq == (m_flag && cfg_irq_en), "irq", 32'(irq), 32'(m_flag && cfg_irq_en));
            chk(res_bus == {m_res[3], m_res[2], m_res[1], m_res[0]}, "res_bus",
                res_bus, {m_res[3], m_res[2], m_res[1], m_res[0]});
            if (conv_done) conv_done = 1'b0;
            if (conv_start) begin
                // R2: strobe carries the expected channel
                chk(m_active && conv_ch == 2'(m_seq[m_pos]), "R2 conv_ch at strobe",
                    32'(conv_ch), 32'(m_seq.size() > 0 ? m_seq[m_pos] : -1));
                pend_ch = conv_ch;
                cd_cnt  = LAT - 1;
            end else if (cd_cnt > 0) begin
                cd_cnt--;
                if (cd_cnt == 0) begin
                    cnv_n++;
                    conv_data = {pend_ch, 6'(cnv_n)};
                    conv_done = 1'b1;
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog %s: actual=%0d expected=%0d", cur_req, cyc, 150000);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic drv();
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_start();
        drv(); cmd_start = 1'b1;
        drv(); cmd_start = 1'b0;
    endtask

    task automatic pulse_stop();
        drv(); cmd_stop = 1'b1;
        drv(); cmd_stop = 1'b0;
    endtask

    task automatic pulse_clr();
        drv(); flag_clr = 1'b1;
        drv(); flag_clr = 1'b0;
    endtask

    task automatic wait_convs(input int n);
        int k = 0;
        while (k < n) begin
            @(posedge clk);
            if (conv_done) k++;
        end
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        drv();
        cur_req = "R1";
        chk(res_bus == 32'd0, "R1 results after reset", res_bus, 32'd0);
        chk(!busy && !done_flag && !irq && !conv_start, "R1 idle outputs",
            {busy, done_flag, irq, conv_start}, 32'd0);

        // Mode 0, fixed single.
        cur_req = "R3";
        cfg_irq_en = 1'b1; cfg_mode = 3'd0; cfg_fixed_ch = 2'd2;
        pulse_start();
        wait_idle();
        chk(done_flag && irq, "R3 flag and irq after single", {done_flag, irq}, 32'd3);
        chk(res_bus[23:16] != 8'd0, "R3 register 2 written", res_bus[23:16], 32'hff);
        pulse_clr();

        // Mode 1 without the group option, then with it.
        cur_req = "R4";
        cfg_mode = 3'd1; cfg_fixed_ch = 2'd1; cfg_grp_irq = 1'b0;
        pulse_start();
        wait_convs(6);
        cur_req = "R5";
        chk(!done_flag, "R5 no flag without group option", done_flag, 32'd0);
        cur_req = "R10";
        cfg_fixed_ch = 2'd3;
        pulse_start();
        wait_convs(1);
        cur_req = "R11";
        pulse_stop();
        wait_idle();
        chk(!busy, "R11 idle after stop", busy, 32'd0);
        cur_req = "R5";
        cfg_grp_irq = 1'b1;
        pulse_start();
        wait_convs(9);
        pulse_stop();
        wait_idle();
        pulse_clr();

        // Mode 2, scan single.
        cur_req = "R6";
        cfg_mode = 3'd2; cfg_scan_mask = 4'b1011;
        pulse_start();
        wait_idle();
        chk(done_flag, "R6 flag after scan", done_flag, 32'd1);
        pulse_clr();

        cur_req = "R7";
        cfg_scan_mask = 4'b0100;
        pulse_start();
        wait_idle();
        chk(done_flag, "R7 single-bit scan flag", done_flag, 32'd1);
        pulse_clr();

        // Mode 3, scan continuous.
        cur_req = "R8";
        cfg_mode = 3'd3; cfg_scan_mask = 4'b1010;
        pulse_start();
        wait_convs(7);
        pulse_stop();
        wait_idle();
        pulse_clr();

        // Mode 4, dual continuous.
        cur_req = "R9";
        cfg_mode = 3'd4; cfg_dual_a = 2'd3; cfg_dual_b = 2'd0;
        pulse_start();
        wait_convs(10);
        pulse_stop();
        wait_idle();
        chk(done_flag, "R9 flag after group of four", done_flag, 32'd1);
        pulse_clr();

        // Ignored starts.
        cur_req = "R10";
        cfg_mode = 3'd2; cfg_scan_mask = 4'b0000;
        pulse_start();
        repeat (4) drv();
        chk(!busy, "R10 zero mask ignored", busy, 32'd0);
        cfg_mode = 3'd5; cfg_scan_mask = 4'b1111;
        pulse_start();
        repeat (4) drv();
        chk(!busy, "R10 reserved mode ignored", busy, 32'd0);

        cur_req = "R11";
        pulse_stop();
        repeat (3) drv();
        chk(!busy && !done_flag, "R11 stop while idle", {busy, done_flag}, 32'd0);

        // Set wins over a held clear; irq gated by its enable.
        cur_req = "R12";
        cfg_mode = 3'd0; cfg_fixed_ch = 2'd0;
        drv(); flag_clr = 1'b1;
        pulse_start();
        wait_idle();
        drv(); flag_clr = 1'b0;
        cfg_irq_en = 1'b0;
        pulse_start();
        wait_idle();
        drv();
        chk(done_flag && !irq, "R12 irq masked", {done_flag, irq}, 32'd2);
        cfg_irq_en = 1'b1;
        drv();
        chk(irq, "R12 irq enabled", irq, 32'd1);
        pulse_clr();
        repeat (3) drv();

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule